// File: doc/BRIEF.md
# Ternary Masked-Search CAM with Match Walker

This block is a small content-addressable array. Each row holds one data word and a row-valid bit. A search takes a key and a care mask and compares the key against every row in the same clock edge. A mask bit of 1 marks a bit position as known. A mask bit of 0 makes that position don't-care. Every valid row that agrees with the key on all known positions gets its own match flag. A search replaces all earlier flags.

A priority resolver watches the flag vector and presents the lowest-numbered flagged row: its index and its full stored word. A walk command clears that row's flag, so the next match appears on the following cycle. The flagged set can also be changed in place, without reading it out. A group write overwrites the masked bits of every flagged row. A delete invalidates every flagged row. A span command fills in the flags of the valid rows that lie between the lowest and highest flagged rows.

All commands arrive on one command bus. The write data shares the key bus. All state is registered, so every result appears on the resolver outputs one cycle after its command.

Top module: `cam_masked_search`

## Requirements
- R1: After reset, and after any later reset, no row is valid and no flag is set: `hit_valid` is 0, `hit_index` is 0, and a search with an all-zero mask flags nothing.
- R2: Command 1 (write) stores `key` into row `addr` and marks that row valid. A later full-mask search for that word flags the row.
- R3: During a search (command 2), a bit position with mask bit 1 must equal the key bit. A position with mask bit 0 matches either stored value.
- R4: A search sets the flag of every matching valid row at once and clears the flags of all other rows. A search that matches nothing leaves every flag clear and `hit_valid` low.
- R5: One cycle after any command, `hit_valid` is high exactly when at least one flag is set. When it is high, `hit_index` is the lowest flagged row and `hit_word` is that row's current stored word. This holds for rows 0 and ROWS-1 as well.
- R6: Command 3 (next) clears only the flag of the lowest flagged row. With no flag set, it changes nothing.
- R7: Command 4 (group write) replaces, in every flagged row, the bits where `mask` is 1 with the matching `key` bits. Other bits, unflagged rows and the flags themselves stay unchanged. With no flags set, it changes no row.
- R8: Command 5 (delete) marks every flagged row invalid and clears all flags. An invalid row is never flagged by any search, even one with an all-zero mask.
- R9: Command 6 (span) sets the flag of every valid row between the lowest and highest flagged rows, inclusive, and clears no flag. With a single flag set, it adds nothing.
- R10: Commands 0 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code (0 idle, 1 write, 2 search, 3 next, 4 group write, 5 delete, 6 span, 7 idle) |
| addr | input | $clog2(ROWS) | Row selected by a write |
| key | input | WIDTH | Search key, write data, or group-write data |
| mask | input | WIDTH | Care mask for search and group write (1 = bit used) |
| hit_valid | output | 1 | At least one flag is set |
| hit_index | output | $clog2(ROWS) | Lowest flagged row (0 when no flag is set) |
| hit_word | output | WIDTH | Stored word of the lowest flagged row (0 when no flag is set) |

## Verification
The hardest cases to reach are the ones that depend on the flag state left by earlier commands. These are a group write or span acting on a sparse flag set, a delete followed by an all-zero-mask search that must skip the removed rows, and a walk that runs past the last flag. The stimulus builds these states in order. It first fills scattered rows, then narrows the flag set with partial masks, then walks or edits the set. Between edits it runs fresh full-mask searches, so the changed and unchanged rows can be read back through the resolver.

// File: rtl/cam_pkg.sv
package cam_pkg;

    parameter int CAM_ROWS  = 16;
    parameter int CAM_WIDTH = 32;

    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_WRITE  = 3'd1,
        CMD_SEARCH = 3'd2,
        CMD_NEXT   = 3'd3,
        CMD_GROUP  = 3'd4,
        CMD_DELETE = 3'd5,
        CMD_SPAN   = 3'd6,
        CMD_IDLE2  = 3'd7
    } cam_cmd_e;

    // Ternary compare: only positions with a care bit set take part.
    function automatic logic ternary_hit(input logic [CAM_WIDTH-1:0] stored,
                                         input logic [CAM_WIDTH-1:0] probe,
                                         input logic [CAM_WIDTH-1:0] care);
        return ((stored ^ probe) & care) == '0;
    endfunction

    // Merge new bits into an old word where the care bits are set.
    function automatic logic [CAM_WIDTH-1:0] masked_merge(input logic [CAM_WIDTH-1:0] old_w,
                                                          input logic [CAM_WIDTH-1:0] new_w,
                                                          input logic [CAM_WIDTH-1:0] care);
        return (old_w & ~care) | (new_w & care);
    endfunction

endpackage

// File: rtl/cam_row_array.sv
module cam_row_array
    import cam_pkg::*;
#(
    parameter int ROWS  = CAM_ROWS,
    parameter int WIDTH = CAM_WIDTH,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  cam_cmd_e         op,
    input  logic [IDX_W-1:0] addr,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] mask,
    input  logic [ROWS-1:0]  flags,
    output logic [ROWS-1:0]  match_vec,
    output logic [ROWS-1:0]  row_valid,
    output logic [WIDTH-1:0] words [ROWS]
);

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            logic [WIDTH-1:0] word_q;
            logic             valid_q;
            logic             sel_write;

            assign sel_write = (op == CMD_WRITE) && (addr == IDX_W'(r));

            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q  <= '0;
                    valid_q <= 1'b0;
                end else if (sel_write) begin
                    word_q  <= key;
                    valid_q <= 1'b1;
                end else if (op == CMD_GROUP && flags[r]) begin
                    word_q  <= masked_merge(word_q, key, mask);
                end else if (op == CMD_DELETE && flags[r]) begin
                    valid_q <= 1'b0;
                end
            end

            assign match_vec[r] = valid_q && ternary_hit(word_q, key, mask);
            assign row_valid[r] = valid_q;
            assign words[r]     = word_q;
        end
    endgenerate

endmodule

// File: rtl/cam_flag_ctrl.sv
module cam_flag_ctrl
    import cam_pkg::*;
#(
    parameter int ROWS = CAM_ROWS
) (
    input  logic            clk,
    input  logic            rst,
    input  cam_cmd_e        op,
    input  logic [ROWS-1:0] match_vec,
    input  logic [ROWS-1:0] row_valid,
    output logic [ROWS-1:0] flags_q
);

    logic [ROWS-1:0] low_oh;
    logic [ROWS-1:0] high_oh;
    logic [ROWS:0]   span_ext;
    logic [ROWS-1:0] flags_d;

    always_comb begin
        low_oh  = flags_q & (~flags_q + ROWS'(1));
        high_oh = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (flags_q[i]) high_oh = ROWS'(1) << i;
        end
        span_ext = ({1'b0, high_oh} << 1) - {1'b0, low_oh};
    end

    always_comb begin
        unique case (op)
            CMD_SEARCH: flags_d = match_vec;
            CMD_NEXT:   flags_d = flags_q & ~low_oh;
            CMD_DELETE: flags_d = '0;
            CMD_SPAN:   flags_d = flags_q | (span_ext[ROWS-1:0] & row_valid);
            default:    flags_d = flags_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

endmodule

// File: rtl/cam_resolver.sv
module cam_resolver
    import cam_pkg::*;
#(
    parameter int ROWS = CAM_ROWS,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic [ROWS-1:0]  flags,
    output logic             any_flag,
    output logic [IDX_W-1:0] first_idx
);

    always_comb begin
        first_idx = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (flags[i]) first_idx = IDX_W'(i);
        end
        any_flag = |flags;
    end

endmodule

// File: rtl/cam_masked_search.sv
module cam_masked_search
    import cam_pkg::*;
#(
    parameter int ROWS  = CAM_ROWS,
    parameter int WIDTH = CAM_WIDTH,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cmd,
    input  logic [IDX_W-1:0] addr,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] mask,
    output logic             hit_valid,
    output logic [IDX_W-1:0] hit_index,
    output logic [WIDTH-1:0] hit_word
);

    cam_cmd_e         op;
    logic [ROWS-1:0]  match_vec;
    logic [ROWS-1:0]  row_valid;
    logic [ROWS-1:0]  flags_q;
    logic [WIDTH-1:0] words [ROWS];
    logic             any_flag;
    logic [IDX_W-1:0] first_idx;

    assign op = cam_cmd_e'(cmd);

    cam_row_array #(.ROWS(ROWS), .WIDTH(WIDTH)) u_rows (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .addr      (addr),
        .key       (key),
        .mask      (mask),
        .flags     (flags_q),
        .match_vec (match_vec),
        .row_valid (row_valid),
        .words     (words)
    );

    cam_flag_ctrl #(.ROWS(ROWS)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .match_vec (match_vec),
        .row_valid (row_valid),
        .flags_q   (flags_q)
    );

    cam_resolver #(.ROWS(ROWS)) u_res (
        .flags     (flags_q),
        .any_flag  (any_flag),
        .first_idx (first_idx)
    );

    assign hit_valid = any_flag;
    assign hit_index = first_idx;
    assign hit_word  = any_flag ? words[first_idx] : '0;

endmodule

// File: rtl/cam_masked_search_chk.sv
module cam_masked_search_chk
    import cam_pkg::*;
#(
    parameter int ROWS = CAM_ROWS,
    localparam int IDX_W = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cmd,
    input logic             hit_valid,
    input logic [IDX_W-1:0] hit_index,
    input logic [ROWS-1:0]  flags,
    input logic [ROWS-1:0]  row_valid
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (flags == '0 && row_valid == '0 && !hit_valid));

    assert_first_flag_R5: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> (flags[hit_index] &&
                       ((flags & ~({ROWS{1'b1}} << hit_index)) == '0)));

    assert_idle_flags_R5: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |-> (flags == '0));

    assert_next_drops_one_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_NEXT && flags != '0) |=>
            ($countones(flags) == $countones($past(flags)) - 1));

    assert_next_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_NEXT && flags == '0) |=> (flags == '0));

    assert_group_keeps_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_GROUP) |=> $stable(flags));

    assert_flags_valid_only_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SEARCH) |=> ((flags & ~row_valid) == '0));

    assert_delete_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_DELETE) |=> (flags == '0));

    assert_span_grows_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SPAN) |=> (($past(flags) & ~flags) == '0));

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_IDLE || cmd == CMD_IDLE2) |=> ($stable(flags) && $stable(row_valid)));

endmodule

bind cam_masked_search cam_masked_search_chk #(.ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .hit_valid (hit_valid),
    .hit_index (hit_index),
    .flags     (flags_q),
    .row_valid (row_valid)
);

// File: tb/tb_cam_masked_search.sv
module tb_cam_masked_search;

    localparam int ROWS  = 16;
    localparam int WIDTH = 32;
    localparam int IDX_W = $clog2(ROWS);

    typedef struct packed {
        logic [2:0]       cmd;
        logic [IDX_W-1:0] addr;
        logic [WIDTH-1:0] key;
        logic [WIDTH-1:0] mask;
        logic             ev;
        logic [IDX_W-1:0] ei;
        logic [WIDTH-1:0] ew;
        logic [3:0]       req;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 4'd2,  32'h1234_5678, 32'h0,         1'b0, 4'd0,  32'h0,         4'd2},  // R2 load
        '{3'd1, 4'd5,  32'h1234_ABCD, 32'h0,         1'b0, 4'd0,  32'h0,         4'd2},
        '{3'd1, 4'd9,  32'hFFFF_5678, 32'h0,         1'b0, 4'd0,  32'h0,         4'd2},
        '{3'd1, 4'd12, 32'h1234_5678, 32'h0,         1'b0, 4'd0,  32'h0,         4'd2},
        '{3'd2, 4'd0,  32'h1234_5678, 32'hFFFF_FFFF, 1'b1, 4'd2,  32'h1234_5678, 4'd2},  // R2 full mask
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b1, 4'd12, 32'h1234_5678, 4'd6},  // R6 walk
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b0, 4'd0,  32'h0,         4'd6},
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b0, 4'd0,  32'h0,         4'd6},  // R6 empty next
        '{3'd2, 4'd0,  32'h1234_0000, 32'hFFFF_0000, 1'b1, 4'd2,  32'h1234_5678, 4'd3},  // R3 upper half
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b1, 4'd5,  32'h1234_ABCD, 4'd3},
        '{3'd2, 4'd0,  32'h0000_5678, 32'h0000_FFFF, 1'b1, 4'd2,  32'h1234_5678, 4'd4},  // R4 replaces
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b1, 4'd9,  32'hFFFF_5678, 4'd4},
        '{3'd2, 4'd0,  32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0, 4'd0,  32'h0,         4'd4},  // R4 no match
        '{3'd2, 4'd0,  32'h0,         32'h0,         1'b1, 4'd2,  32'h1234_5678, 4'd8},  // R8 all care off
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b1, 4'd5,  32'h1234_ABCD, 4'd8},
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b1, 4'd9,  32'hFFFF_5678, 4'd8},
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b1, 4'd12, 32'h1234_5678, 4'd8},
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b0, 4'd0,  32'h0,         4'd8},
        '{3'd2, 4'd0,  32'h1234_0000, 32'hFFFF_0000, 1'b1, 4'd2,  32'h1234_5678, 4'd3},
        '{3'd4, 4'd0,  32'h0000_00EE, 32'h0000_00FF, 1'b1, 4'd2,  32'h1234_56EE, 4'd7},  // R7 group write
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b1, 4'd5,  32'h1234_ABEE, 4'd7},
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b1, 4'd12, 32'h1234_56EE, 4'd7},
        '{3'd2, 4'd0,  32'hFFFF_5678, 32'hFFFF_FFFF, 1'b1, 4'd9,  32'hFFFF_5678, 4'd7},  // R7 unflagged row kept
        '{3'd2, 4'd0,  32'h1234_56EE, 32'hFFFF_FFFF, 1'b1, 4'd2,  32'h1234_56EE, 4'd9},
        '{3'd6, 4'd0,  32'h0,         32'h0,         1'b1, 4'd2,  32'h1234_56EE, 4'd9},  // R9 span
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b1, 4'd5,  32'h1234_ABEE, 4'd9},
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b1, 4'd9,  32'hFFFF_5678, 4'd9},
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b1, 4'd12, 32'h1234_56EE, 4'd9},
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b0, 4'd0,  32'h0,         4'd9},
        '{3'd2, 4'd0,  32'h1234_0000, 32'hFFFF_0000, 1'b1, 4'd2,  32'h1234_56EE, 4'd8},
        '{3'd5, 4'd0,  32'h0,         32'h0,         1'b0, 4'd0,  32'h0,         4'd8},  // R8 delete
        '{3'd2, 4'd0,  32'h0,         32'h0,         1'b1, 4'd9,  32'hFFFF_5678, 4'd8},
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b0, 4'd0,  32'h0,         4'd8},
        '{3'd4, 4'd0,  32'h0,         32'hFFFF_FFFF, 1'b0, 4'd0,  32'h0,         4'd7},  // R7 no flags
        '{3'd2, 4'd0,  32'h0,         32'h0,         1'b1, 4'd9,  32'hFFFF_5678, 4'd7},
        '{3'd6, 4'd0,  32'h0,         32'h0,         1'b1, 4'd9,  32'hFFFF_5678, 4'd9},  // R9 single flag
        '{3'd7, 4'd3,  32'h5555_5555, 32'hFFFF_FFFF, 1'b1, 4'd9,  32'hFFFF_5678, 4'd10}, // R10 idle
        '{3'd3, 4'd0,  32'h0,         32'h0,         1'b0, 4'd0,  32'h0,         4'd9}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       cmd = 3'd0;
    logic [IDX_W-1:0] addr = '0;
    logic [WIDTH-1:0] key = '0;
    logic [WIDTH-1:0] mask = '0;
    logic             hit_valid;
    logic [IDX_W-1:0] hit_index;
    logic [WIDTH-1:0] hit_word;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    cam_masked_search #(.ROWS(ROWS), .WIDTH(WIDTH)) dut (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .addr      (addr),
        .key       (key),
        .mask      (mask),
        .hit_valid (hit_valid),
        .hit_index (hit_index),
        .hit_word  (hit_word)
    );

    task automatic check_out(input logic ev, input logic [IDX_W-1:0] ei,
                             input logic [WIDTH-1:0] ew, input string tag);
        n_checks++;
        if (hit_valid !== ev || hit_index !== ei || hit_word !== ew) begin
            n_fails++;
            $display("FAIL %s: got valid=%0b index=%0d word=%08h, expected valid=%0b index=%0d word=%08h",
                     tag, hit_valid, hit_index, hit_word, ev, ei, ew);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [IDX_W-1:0] a,
                        input logic [WIDTH-1:0] k, input logic [WIDTH-1:0] m,
                        input logic ev, input logic [IDX_W-1:0] ei,
                        input logic [WIDTH-1:0] ew, input string tag);
        cmd  = c;
        addr = a;
        key  = k;
        mask = m;
        @(negedge clk);
        cmd = 3'd0;
        check_out(ev, ei, ew, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_out(1'b0, '0, '0, "R1 reset outputs");
        step(3'd2, '0, '0, '0, 1'b0, '0, '0, "R1 empty after reset");

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].cmd, VECS[i].addr, VECS[i].key, VECS[i].mask,
                 VECS[i].ev, VECS[i].ei, VECS[i].ew,
                 $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R5 boundary rows 0 and ROWS-1
        step(3'd1, 4'd0,  32'h0000_0001, '0, 1'b0, '0, '0, "R2 load row 0");
        step(3'd1, 4'd15, 32'hAAAA_5555, '0, 1'b0, '0, '0, "R2 load row 15");
        step(3'd2, '0, '0, '0, 1'b1, 4'd0, 32'h0000_0001, "R5 first row");
        step(3'd3, '0, '0, '0, 1'b1, 4'd9, 32'hFFFF_5678, "R5 middle row");
        step(3'd3, '0, '0, '0, 1'b1, 4'd15, 32'hAAAA_5555, "R5 last row");
        step(3'd3, '0, '0, '0, 1'b0, '0, '0, "R5 walk exhausted");

        // R1 reset in the middle of a run, with flags set
        step(3'd2, '0, '0, '0, 1'b1, 4'd0, 32'h0000_0001, "R4 refill flags");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_out(1'b0, '0, '0, "R1 mid-run reset clears flags");
        step(3'd2, '0, '0, '0, 1'b0, '0, '0, "R1 mid-run reset clears rows");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule